// File: doc/BRIEF.md
# Dual-Clock FIFO with Mid-Run Reset

This block carries data words from a write clock domain to an unrelated, typically faster, read clock domain through a small storage array. The write and read positions are exchanged between the domains as Gray-coded counters through two-stage synchronizers. The read port shows the word at the head of the queue whenever it is not empty (first-word fall-through), and a read enable removes that word.

A single reset request input can clear the queue at any moment, including in the middle of a burst. The request may be shorter than one read-clock period. Each domain has its own pair of reset flops that the request presets asynchronously. The first flop clears itself on the next edge of its own clock, and the second flop follows one edge later. The second flop's output clears that side's position counter and synchronizer, and it forces the local status flag: full on the write side, empty on the read side. Reset therefore takes hold at once, ends in step with each local clock, and blocks every transfer until the flags have real values again. The storage array itself is never cleared.

Top module: `xdom_fifo`

## Requirements
- R1: While the reset request is high, and for any request length, including one shorter than a read-clock period, wr_full reads 1 and rd_empty reads 1 without waiting for any clock edge.
- R2: After the request falls, wr_full stays 1 after the first rising edge of wr_clk and drops to 0 after the second rising edge when the queue was cleared.
- R3: After a reset, the FIFO shows empty and not full. No word accepted before the reset is ever presented afterwards, and words written after the reset are read back.
- R4: Every accepted word is presented exactly once and in write order, across any mix of read stalls and reset timing.
- R5: With no reads, wr_full rises after exactly DEPTH (8 by default) accepted writes. A write attempted while full is dropped and does not move the write position. The queue accepts writes again once reads have freed space.
- R6: A read attempted while empty is ignored and does not move the read position. The next word written is the next word presented.
- R7: Reset does not clear storage. Right after a reset, rd_data shows the word last written to storage slot 0, which is the slot both positions restart from, while rd_empty is 1.
- R8: A word written into an empty FIFO makes rd_empty fall within 6 read-clock cycles of the write side's next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request; the word is accepted on a rising wr_clk edge when wr_full is 0 |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No space, or write side in reset |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Remove the head word on a rising rd_clk edge when rd_empty is 0 |
| rd_data | output | DW | Head word (valid when rd_empty is 0) |
| rd_empty | output | 1 | No word, or read side in reset |
| rst_req | input | 1 | Reset request, active high, any length, any phase |

## Verification
The bench goes after reset pulses that land at many different phases against both clocks in the middle of a burst. A design that let a pointer move during recovery would present stale or duplicated words, and each word carries a per-reset tag and sequence number so that this shows up at once. It also probes a sub-cycle request that falls between read edges, which a design with a synchronous-only reset would miss. It counts the exact release edge on the write side, drives writes into a full queue and reads from an empty one, which a missing guard would turn into overwritten or phantom words, and reads the restart slot after reset, where a design that wiped storage would show zero.

// File: rtl/xdom_fifo_pkg.sv
`timescale 1ns/1ps
package xdom_fifo_pkg;
  localparam int GW = 32;
  localparam int SYNC_STAGES = 2;
  typedef logic [GW-1:0] gword_t;

  function automatic gword_t to_gray(gword_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic gword_t from_gray(gword_t g);
    gword_t b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // words held, counted modulo 2**pw
  function automatic gword_t fill_level(gword_t head, gword_t tail, int pw);
    gword_t mask;
    mask = (gword_t'(1) << pw) - gword_t'(1);
    return (head - tail) & mask;
  endfunction
endpackage

// File: rtl/xdom_rst_bridge.sv
`timescale 1ns/1ps
module xdom_rst_bridge (
  input  logic clk,
  input  logic req,
  output logic rst
);
  logic arm_q, hold_q;

  always_ff @(posedge clk or posedge req) begin
    if (req) begin
      arm_q  <= 1'b1;
      hold_q <= 1'b1;
    end else begin
      arm_q  <= 1'b0;
      hold_q <= arm_q;
    end
  end

  assign rst = hold_q;

  // R2: local reset ends only after being seen on two own-clock edges
  assert_two_edge_release_R2: assert property (@(posedge clk)
    $fell(rst) |-> $past(rst, 2));
endmodule

// File: rtl/xdom_gray_sync.sv
`timescale 1ns/1ps
module xdom_gray_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import xdom_fifo_pkg::*;
  logic [W-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/xdom_wr_ctl.sv
`timescale 1ns/1ps
module xdom_wr_ctl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW:0]   rgray_s,
  output logic          full,
  output logic          push,
  output logic [AW-1:0] addr,
  output logic [AW:0]   gray
);
  import xdom_fifo_pkg::*;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] bin, bin_nx, rbin_s, level;

  assign rbin_s = PW'(from_gray(gword_t'(rgray_s)));
  assign level  = PW'(fill_level(gword_t'(bin), gword_t'(rbin_s), PW));
  assign full   = rst | (level == PW'(DEPTH));
  assign push   = en & ~full;
  assign bin_nx = bin + PW'(1);
  assign addr   = bin[AW-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else if (push) begin
      bin  <= bin_nx;
      gray <= PW'(to_gray(gword_t'(bin_nx)));
    end
  end

  // R5: refused write leaves the write position alone
  assert_hold_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (en && full) |=> $stable(bin));
  // R5: never more than DEPTH words held
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    level <= PW'(DEPTH));
  // R4: crossing code moves one bit at a time
  assert_wr_gray_step_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/xdom_rd_ctl.sv
`timescale 1ns/1ps
module xdom_rd_ctl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW:0]   wgray_s,
  output logic          empty,
  output logic          pop,
  output logic [AW-1:0] addr,
  output logic [AW:0]   gray
);
  import xdom_fifo_pkg::*;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] bin, bin_nx, wbin_s, level;

  assign wbin_s = PW'(from_gray(gword_t'(wgray_s)));
  assign level  = PW'(fill_level(gword_t'(wbin_s), gword_t'(bin), PW));
  assign empty  = rst | (gray == wgray_s);
  assign pop    = en & ~empty;
  assign bin_nx = bin + PW'(1);
  assign addr   = bin[AW-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bin  <= '0;
      gray <= '0;
    end else if (pop) begin
      bin  <= bin_nx;
      gray <= PW'(to_gray(gword_t'(bin_nx)));
    end
  end

  // R6: refused read leaves the read position alone
  assert_hold_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (en && empty) |=> $stable(bin));
  // R4: read side never runs past the written words
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    level <= PW'(DEPTH));
  // R4: crossing code moves one bit at a time
  assert_rd_gray_step_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/xdom_fifo.sv
`timescale 1ns/1ps
module xdom_fifo #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  input  logic          rst_req
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  // named internal events
  logic          wr_rst, rd_rst, wr_push, rd_pop;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [DW-1:0] store [DEPTH];

  xdom_rst_bridge u_wr_rst (.clk(wr_clk), .req(rst_req), .rst(wr_rst));
  xdom_rst_bridge u_rd_rst (.clk(rd_clk), .req(rst_req), .rst(rd_rst));

  xdom_gray_sync #(.W(PW)) u_rptr_to_wr (
    .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s));
  xdom_gray_sync #(.W(PW)) u_wptr_to_rd (
    .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s));

  xdom_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .en(wr_en), .rgray_s(rd_gray_s),
    .full(wr_full), .push(wr_push), .addr(wr_addr), .gray(wr_gray));
  xdom_rd_ctl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .en(rd_en), .wgray_s(wr_gray_s),
    .empty(rd_empty), .pop(rd_pop), .addr(rd_addr), .gray(rd_gray));

  // storage has no reset: contents survive a clear
  always_ff @(posedge wr_clk) begin
    if (wr_push) store[wr_addr] <= wr_data;
  end
  assign rd_data = store[rd_addr];

  // R1: request alone blocks both ports at every edge it covers
  assert_full_on_request_R1: assert property (@(posedge wr_clk)
    rst_req |-> wr_full);
  assert_empty_on_request_R1: assert property (@(posedge rd_clk)
    rst_req |-> rd_empty);
  // R3: no transfer while a side is held in reset
  assert_no_push_in_reset_R3: assert property (@(posedge wr_clk)
    wr_rst |-> !wr_push);
endmodule

// File: tb/xdom_fifo_tb.sv
`timescale 1ns/1ps
module xdom_fifo_tb;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rst_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, rd_empty;

  int checks = 0, errors = 0;
  logic [3:0] epoch = 4'd0;
  int wr_seq = 0, rd_seq = 0;
  bit wr_done = 0, rst_done = 0;

  xdom_fifo #(.DW(DW), .AW(AW)) u_dut (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
    .rst_req(rst_req));

  always #2.5 wr_clk = ~wr_clk;
  always #1.45 rd_clk = ~rd_clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_one(logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_one(output logic [DW-1:0] d, input string req);
    @(negedge rd_clk);
    chk(!rd_empty, req, "word expected", rd_empty, 0);
    d = rd_data; rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic writer(int n);
    forever begin
      @(negedge wr_clk);
      if (wr_seq >= n) begin wr_en = 1'b0; break; end
      wr_en = 1'b1;
      wr_data = {epoch, 12'(wr_seq)};
      if (!wr_full) wr_seq++;
    end
  endtask

  task automatic reader(int t);
    int idle = 0, cyc = 0;
    forever begin
      @(negedge rd_clk);
      cyc++;
      if (wr_done && rst_done && idle >= 20) begin rd_en = 1'b0; break; end
      if (!rd_empty) begin
        idle = 0;
        chk(rd_data[15:12] == epoch, "R3", "stale word after reset", rd_data, {epoch, 12'(rd_seq)});
        chk(rd_data[11:0] == 12'(rd_seq), "R4", "order", rd_data, {epoch, 12'(rd_seq)});
        if (wr_done || ((cyc + t) % (t % 3 + 1)) == 0) begin
          rd_en = 1'b1; rd_seq++;
        end else rd_en = 1'b0;
      end else begin
        rd_en = 1'b0; idle++;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int n;
    // power-up reset
    #1.007 rst_req = 1'b1;
    #0.1;
    chk(wr_full, "R1", "full during request", wr_full, 1);
    chk(rd_empty, "R1", "empty during request", rd_empty, 1);
    #5 rst_req = 1'b0;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    chk(rd_empty, "R3", "empty after reset", rd_empty, 1);
    chk(!wr_full, "R3", "not full after reset", wr_full, 0);

    // fill to capacity, then a refused write
    for (int i = 0; i < DEPTH; i++) wr_one(16'h1000 + 16'(i));
    chk(wr_full, "R5", "full after DEPTH writes", wr_full, 1);
    wr_one(16'hBEEF);
    repeat (8) @(negedge rd_clk);
    for (int i = 0; i < DEPTH; i++) begin
      rd_one(d, "R5");
      chk(d == 16'h1000 + 16'(i), "R5", "drain order", d, 16'h1000 + i);
    end
    chk(rd_empty, "R6", "empty after drain", rd_empty, 1);
    // read while empty
    @(negedge rd_clk); rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    repeat (4) @(negedge wr_clk);
    chk(!wr_full, "R5", "space freed", wr_full, 0);
    wr_one(16'h2222);
    n = 0;
    while (rd_empty && n < 20) begin @(negedge rd_clk); n++; end
    chk(n <= 6, "R8", "visibility latency", n, 6);
    rd_one(d, "R6");
    chk(d == 16'h2222, "R6", "word after empty read", d, 16'h2222);

    // leave stale words, then a sub-cycle reset
    for (int i = 0; i < 3; i++) wr_one(16'h3330 + 16'(i));
    @(negedge wr_clk);
    #1.007 rst_req = 1'b1;
    #0.1;
    chk(wr_full, "R1", "full on short request", wr_full, 1);
    chk(rd_empty, "R1", "empty on short request", rd_empty, 1);
    #0.9 rst_req = 1'b0;
    @(negedge wr_clk);
    chk(wr_full, "R2", "full after first edge", wr_full, 1);
    @(negedge wr_clk);
    chk(!wr_full, "R2", "released after second edge", wr_full, 0);
    repeat (10) @(negedge rd_clk);
    chk(rd_empty, "R3", "stale words gone", rd_empty, 1);
    chk(rd_data == 16'h2222, "R7", "storage kept", rd_data, 16'h2222);
    wr_one(16'h4440);
    repeat (8) @(negedge rd_clk);
    rd_one(d, "R3");
    chk(d == 16'h4440, "R3", "first word after reset", d, 16'h4440);

    // sweep of reset phases during bursts
    for (int t = 0; t < 24; t++) begin
      epoch = epoch + 4'd1; wr_seq = 0; rd_seq = 0;
      wr_done = 0; rst_done = 0;
      fork
        begin writer(30); wr_done = 1; end
        reader(t);
        begin
          realtime dly;
          dly = 0.007 + 0.025 * ((t * 137 + 11) % 2400);
          if (t % 5 == 4) dly = dly + 150.0;
          #(dly);
          rst_req = 1'b1;
          epoch = epoch + 4'd1; wr_seq = 0; rd_seq = 0;
          #2.9 rst_req = 1'b0;
          rst_done = 1;
        end
      join
      chk(rd_seq == wr_seq, "R4", "words read vs written", rd_seq, wr_seq);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule